// File: doc/BRIEF.md
# Oversampled Serial Word Receiver with Error Flags

This block turns an asynchronous serial line into 8-bit words. It runs on a system clock. A one-cycle `tick` enable arrives at sixteen times the bit rate, and all receive timing counts these ticks, not clock cycles. The serial input passes through a two-stage synchronizer. While the receiver is idle it watches for a high-to-low change between two consecutive ticks. That change marks the leading edge of a start bit. From that tick on, a phase counter places every later sample near the centre of its bit.

A frame is a low start bit, eight data bits sent least significant bit first, one parity bit and two high stop bits. When the second stop bit has been sampled, the assembled byte moves into a holding register and `data_ready` rises. The host clears `data_ready` with a one-cycle `ack`. With each stored word the block also reports whether the parity bit disagreed and whether either stop bit was low. If a word finishes while the previous one is still unacknowledged, the block raises an overrun flag and overwrites the held word.

Top module: `uart_rx_core`

## Requirements
- R1: After reset `data_out` is 0 and `data_ready`, `parity_err`, `frame_err` and `overrun_err` are all 0.
- R2: A start is taken only at a tick where the synchronized line reads 0 and read 1 at the previous tick. Six ticks after that edge tick the line is checked again. If it reads 1, the event is a glitch: the receiver goes back to idle and leaves every output unchanged.
- R3: Counting the edge tick as tick 0, data bit k is sampled at tick 22+16k (k = 0..7), the parity bit at tick 150, the first stop bit at tick 166 and the second stop bit at tick 182. The line value at any other tick of the frame has no effect.
- R4: The first data bit sampled becomes `data_out[0]` and the last becomes `data_out[7]`.
- R5: With the default even setting, the expected parity bit is the XOR of the eight data bits. `parity_err` is 1 for a word whose received parity bit differs from it.
- R6: `frame_err` is 1 for a word whose first stop bit, second stop bit, or both were sampled as 0.
- R7: The outputs update at the clock edge of the tick that samples the second stop bit: `data_ready` goes to 1 there, and `data_out` takes the new word. A one-cycle `ack` clears `data_ready`.
- R8: If a word completes while `data_ready` is 1 and `ack` is low, `overrun_err` becomes 1 and `data_out` takes the newer word. `ack` clears `overrun_err`.
- R9: `parity_err` and `frame_err` describe only the most recent word. They and `data_out` change only when a word completes.
- R10: A new start bit whose edge falls on the tick right after the second stop bit's bit period (tick 192) is received correctly, with no idle time between frames.
- R11: The receiver advances only on cycles where `tick` is 1. Every timing in R3 is counted in ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable at sixteen times the bit rate |
| rxd | input | 1 | Asynchronous serial input, high when idle |
| ack | input | 1 | Host acknowledges the held word; clears ready and overrun |
| data_out | output | 8 | Last completed word |
| data_ready | output | 1 | A word is held and not yet acknowledged |
| parity_err | output | 1 | Parity mismatch on the held word |
| frame_err | output | 1 | A stop bit of the held word was low |
| overrun_err | output | 1 | A word was overwritten before acknowledge |

## Verification
The bench drives many frames in which the line carries the right bit only on the exact sample ticks of R3 and the opposite value on every other tick. If the first-sample offset or the sixteen-tick pitch is off by even one tick, the design assembles a wrong byte. The bench checks that `data_ready` is still low one tick before the second stop sample and high just after it, which catches a design that completes a tick early or late. A start pulse that is already high again at its mid-point must leave every output unchanged; a design that skips the recheck would deliver a bogus word. Two back-to-back frames without an acknowledge must set the overrun flag and keep only the second byte, and parity flips and each stop-bit fault must show up on their own flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // Which field of the frame the sequencer is waiting to sample
    typedef enum logic [2:0] {
        F_IDLE  = 3'd0,
        F_START = 3'd1,
        F_DATA  = 3'd2,
        F_PAR   = 3'd3,
        F_STOP1 = 3'd4,
        F_STOP2 = 3'd5
    } rx_field_e;

    // Error status that travels with a completed word
    typedef struct packed {
        logic par_bad;
        logic frm_bad;
    } rx_status_t;

    // A frame is bad when either stop bit was sampled low
    function automatic logic stop_fault(input logic first_stop, input logic second_stop);
        return ~(first_stop & second_stop);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    output logic line_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;

    // Synchronizer chain, reset to the idle level
    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_STAGES-2:0], rxd};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= rxd;
            end
        end
    endgenerate

    assign line_o = chain[SYNC_STAGES-1];

    // Line level seen at the previous tick
    always_ff @(posedge clk) begin
        if (rst)       prev_q <= 1'b1;
        else if (tick) prev_q <= line_o;
    end

    assign fall_o = tick & prev_q & ~line_o;
endmodule

// File: rtl/rx_sequencer.sv
module rx_sequencer
    import uart_rx_pkg::*;
#(
    parameter int OVS          = 16,
    parameter int FIRST_DELAY  = 22,
    parameter int SAMPLE_PHASE = 11,
    parameter int DATA_BITS    = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  logic      fall,
    output rx_field_e field_o,
    output logic      samp_o,
    output logic      done_o
);
    localparam int PW   = $clog2(OVS);
    localparam int IW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    // Phase loaded at the edge so the first compare hits (FIRST_DELAY-OVS) ticks later
    localparam int LOAD = SAMPLE_PHASE + 1 - (FIRST_DELAY - OVS);

    localparam logic [PW-1:0] LOAD_V  = PW'(LOAD);
    localparam logic [PW-1:0] SAMP_V  = PW'(SAMPLE_PHASE);
    localparam logic [PW-1:0] LAST_V  = PW'(OVS - 1);
    localparam logic [IW-1:0] IDX_END = IW'(DATA_BITS - 1);

    rx_field_e      st;
    logic [PW-1:0]  phase;
    logic [IW-1:0]  idx;
    logic           at_samp;

    assign at_samp = (phase == SAMP_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= F_IDLE;
            phase <= '0;
            idx   <= '0;
        end else if (tick) begin
            if (st == F_IDLE) begin
                if (fall) begin
                    st    <= F_START;
                    phase <= LOAD_V;
                    idx   <= '0;
                end
            end else begin
                phase <= (phase == LAST_V) ? '0 : phase + PW'(1);
                if (at_samp) begin
                    unique case (st)
                        F_START: st <= line ? F_IDLE : F_DATA;
                        F_DATA: begin
                            if (idx == IDX_END) st <= F_PAR;
                            else                idx <= idx + IW'(1);
                        end
                        F_PAR:   st <= F_STOP1;
                        F_STOP1: st <= F_STOP2;
                        F_STOP2: st <= F_IDLE;
                        default: st <= F_IDLE;
                    endcase
                end
            end
        end
    end

    assign field_o = st;
    assign samp_o  = tick & (st != F_IDLE) & at_samp;
    assign done_o  = samp_o & (st == F_STOP2);
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 samp,
    input  rx_field_e            field,
    input  logic                 line,
    output logic [DATA_BITS-1:0] data_o,
    output rx_status_t           status_o
);
    logic [DATA_BITS-1:0] sh;
    logic                 par_q;
    logic                 stop1_q;
    logic                 exp_par;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            par_q   <= 1'b0;
            stop1_q <= 1'b1;
        end else if (field == F_IDLE) begin
            // Clean slate before the next start bit is accepted
            sh      <= '0;
            par_q   <= 1'b0;
            stop1_q <= 1'b1;
        end else if (samp) begin
            unique case (field)
                F_DATA:  sh      <= {line, sh[DATA_BITS-1:1]};
                F_PAR:   par_q   <= line;
                F_STOP1: stop1_q <= line;
                default: ;
            endcase
        end
    end

    generate
        if (PARITY_ODD) begin : g_odd
            assign exp_par = ~(^sh);
        end else begin : g_even
            assign exp_par = ^sh;
        end
    endgenerate

    // Valid in the cycle where the second stop bit is sampled
    assign data_o           = sh;
    assign status_o.par_bad = exp_par ^ par_q;
    assign status_o.frm_bad = stop_fault(stop1_q, line);
endmodule

// File: rtl/rx_holding.sv
module rx_holding
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done,
    input  logic                 ack,
    input  logic [DATA_BITS-1:0] data_i,
    input  rx_status_t           status_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 ready_o,
    output logic                 perr_o,
    output logic                 ferr_o,
    output logic                 ovr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            ready_o <= 1'b0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
            ovr_o   <= 1'b0;
        end else if (done) begin
            data_o  <= data_i;
            perr_o  <= status_i.par_bad;
            ferr_o  <= status_i.frm_bad;
            ready_o <= 1'b1;
            ovr_o   <= (ovr_o | ready_o) & ~ack;
        end else if (ack) begin
            ready_o <= 1'b0;
            ovr_o   <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS    = 8,
    parameter int OVS          = 16,
    parameter int FIRST_DELAY  = 22,
    parameter int SAMPLE_PHASE = 11,
    parameter int SYNC_STAGES  = 2,
    parameter bit PARITY_ODD   = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rxd,
    input  logic                 ack,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 data_ready,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 overrun_err
);
    logic                 line_w;
    logic                 fall_w;
    rx_field_e            field_w;
    logic                 samp_w;
    logic                 done_w;
    logic [DATA_BITS-1:0] word_w;
    rx_status_t           stat_w;

    rx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
        .line_o(line_w), .fall_o(fall_w)
    );

    rx_sequencer #(
        .OVS(OVS), .FIRST_DELAY(FIRST_DELAY),
        .SAMPLE_PHASE(SAMPLE_PHASE), .DATA_BITS(DATA_BITS)
    ) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .line(line_w), .fall(fall_w),
        .field_o(field_w), .samp_o(samp_w), .done_o(done_w)
    );

    rx_shifter #(.DATA_BITS(DATA_BITS), .PARITY_ODD(PARITY_ODD)) u_shift (
        .clk(clk), .rst(rst), .samp(samp_w), .field(field_w), .line(line_w),
        .data_o(word_w), .status_o(stat_w)
    );

    rx_holding #(.DATA_BITS(DATA_BITS)) u_hold (
        .clk(clk), .rst(rst), .done(done_w), .ack(ack),
        .data_i(word_w), .status_i(stat_w),
        .data_o(data_out), .ready_o(data_ready), .perr_o(parity_err),
        .ferr_o(frame_err), .ovr_o(overrun_err)
    );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ack,
    input logic          done,
    input logic          samp,
    input logic          line,
    input rx_field_e     field,
    input logic [DW-1:0] data_out,
    input logic          data_ready,
    input logic          parity_err,
    input logic          frame_err,
    input logic          overrun_err
);
    // R2: a start that is high again at its mid-point is dropped
    assert_glitch_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (samp && field == F_START && line) |=> field == F_IDLE);

    // R2: a start that is still low moves on to the data bits
    assert_start_ok_R2: assert property (@(posedge clk) disable iff (rst)
        (samp && field == F_START && !line) |=> field == F_DATA);

    // R7: data_ready only rises after a completed frame
    assert_ready_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> $past(done));

    // R7: acknowledge without a new word clears ready
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && !done) |=> !data_ready);

    // R8: completing over an unacknowledged word raises overrun
    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
        (done && data_ready && !ack) |=> overrun_err);

    // R9: held word and its flags move only on completion
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(data_out) && $stable(parity_err) && $stable(frame_err)));
endmodule

bind uart_rx_core uart_rx_core_chk #(.DW(DATA_BITS)) u_chk (
    .clk(clk), .rst(rst), .ack(ack), .done(done_w), .samp(samp_w),
    .line(line_w), .field(field_w), .data_out(data_out),
    .data_ready(data_ready), .parity_err(parity_err),
    .frame_err(frame_err), .overrun_err(overrun_err)
);

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       ack = 1'b0;
    logic       tick;
    logic [7:0] data_out;
    logic       data_ready, parity_err, frame_err, overrun_err;
    int         tcnt = 0;
    int         cyc  = 0;
    int         n_chk = 0;
    int         n_err = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        tcnt <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
        cyc  <= cyc + 1;
    end
    assign tick = (tcnt == TICK_DIV-1);

    uart_rx_core u0 (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .ack(ack),
        .data_out(data_out), .data_ready(data_ready), .parity_err(parity_err),
        .frame_err(frame_err), .overrun_err(overrun_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Put one value on the line; the design samples it at the tick edge ending this step
    task automatic step(input logic v);
        @(negedge clk);
        rxd = v;
        while (!tick) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    // Frame of 192 ticks; junk puts the inverse bit on every non-sample tick
    task automatic send_frame(input logic [7:0] d, input logic pflip,
                              input logic s1, input logic s2,
                              input bit junk, input bit tchk);
        logic [11:0] fr;
        fr = {s2, s1, (^d) ^ pflip, d, 1'b0};
        for (int m = 0; m < 192; m++) begin
            int  f;
            logic bv;
            f  = m / 16;
            bv = fr[f];
            if (junk && m != 0 && m < 176 && m != 6 + 16*f) bv = ~bv;
            step(bv);
            if (tchk && m == 181) chk("R7 ready low before last stop sample", int'(data_ready), 0);
            if (tchk && m == 182) chk("R7 ready high at last stop sample", int'(data_ready), 1);
        end
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic expect_word(input string req, input logic [7:0] d,
                               input logic pe, input logic fe);
        chk({req, " data"}, int'(data_out), int'(d));
        chk({req, " ready"}, int'(data_ready), 1);
        chk({req, " parity_err"}, int'(parity_err), int'(pe));
        chk({req, " frame_err"}, int'(frame_err), int'(fe));
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 data_out", int'(data_out), 0);
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R1 parity_err", int'(parity_err), 0);
        chk("R1 frame_err", int'(frame_err), 0);
        chk("R1 overrun_err", int'(overrun_err), 0);

        idle(4);
        // R3 R7 R11: exact completion tick, clean frame
        send_frame(8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        expect_word("R7 first word", 8'hA5, 1'b0, 1'b0);
        do_ack();
        chk("R7 ack clears ready", int'(data_ready), 0);

        // R3 R4 R5 R6 R9: sweep of words with sample-only correct line
        for (int k = 0; k < 64; k++) begin
            logic [7:0] d;
            logic pf, s1, s2;
            d  = (k < 8) ? 8'(1 << k) : ((k < 16) ? ~8'(1 << (k-8)) : 8'(k*37 + 11));
            pf = (k % 3 == 1);
            s1 = (k % 5 != 2);
            s2 = (k % 7 != 3);
            idle(2);
            send_frame(d, pf, s1, s2, (k % 2 == 0), 1'b1);
            expect_word("R3 R4 R5 R6 R9 sweep", d, pf, ~(s1 & s2));
            chk("R8 no overrun after ack", int'(overrun_err), 0);
            do_ack();
            chk("R7 ack clears ready in sweep", int'(data_ready), 0);
        end

        // R6: each stop bit alone and both
        idle(2);
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        expect_word("R6 first stop low", 8'h3C, 1'b0, 1'b1);
        do_ack();
        idle(2);
        send_frame(8'h3C, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_word("R6 second stop low", 8'h3C, 1'b0, 1'b1);
        do_ack();
        idle(2);
        send_frame(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_word("R6 R5 both stops low with parity flip", 8'hC3, 1'b1, 1'b1);
        do_ack();
        idle(2);
        send_frame(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_word("R9 flags clear on clean word", 8'h00, 1'b0, 1'b0);
        do_ack();

        // R2: start pulse high again before its mid-point
        idle(3);
        for (int m = 0; m < 5; m++) step(1'b0);
        idle(220);
        chk("R2 glitch leaves ready low", int'(data_ready), 0);
        chk("R2 glitch leaves data", int'(data_out), 0);
        chk("R2 glitch leaves frame_err", int'(frame_err), 0);
        send_frame(8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_word("R2 word after glitch", 8'h5A, 1'b0, 1'b0);
        do_ack();

        // R8 R10: back-to-back frames without acknowledge
        idle(2);
        send_frame(8'h81, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8 no overrun on first", int'(overrun_err), 0);
        send_frame(8'h7E, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_word("R10 R8 second word overwrites", 8'h7E, 1'b1, 1'b0);
        chk("R8 overrun set", int'(overrun_err), 1);
        do_ack();
        chk("R8 ack clears overrun", int'(overrun_err), 0);
        chk("R8 ack clears ready", int'(data_ready), 0);
        idle(2);
        send_frame(8'h42, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_word("R8 next word after ack", 8'h42, 1'b0, 1'b0);
        chk("R8 no overrun after ack", int'(overrun_err), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        if (!finished && cyc > WATCHDOG) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule